// File: doc/BRIEF.md
# Packed Integer Lane Multiplier

This block multiplies the packed integer lanes of two 64-bit words and registers the packed result one cycle after an input strobe. The width of each destination lane is selected per operation as 1, 2, 4 or 8 bytes. The destination lane count is 64 divided by the destination lane width. The source lane width may be smaller than the destination width. In that case each product is widened, and six option bits steer the operation:

- Signed or unsigned operands.
- A rounding bias added to the full product.
- Keeping the upper half of the product instead of the lower half.
- Widening from the even or from the odd source lanes.
- Restricting the operation to lane 0 while the rest of the word keeps the old destination value.

The full product of a lane is always formed to twice the destination width, so the upper half and the rounding carry are exact. A request whose source width exceeds its destination width is rejected. An error pulse is raised and the registered result is left untouched.

Top module: `pmul_unit`

## Requirements
- R1: While reset is asserted and after its release, `result` is 0, `done` is 0 and `size_err` is 0 until the first strobe.
- R2: `done` is high in exactly the cycle after each cycle with `in_valid` high. `result` changes only on such a cycle and holds its value otherwise.
- R3: The size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. With ext bit 4 clear, the source field starting at bit i*S feeds destination lane i at bits i*D. S and D are the source and destination widths in bits. With ext bits 1, 2 and 3 clear, the operands are unsigned and the lane keeps the product modulo 2^D.
- R4: With ext bit 1 set, both operands are sign-extended from bit S-1 before the multiplication.
- R5: With ext bit 3 set, the lane receives bits 2D-1 down to D of the full product.
- R6: With ext bit 2 set, 2^(D-1) is added to the full product before the half is selected.
- R7: With ext bits 4 and 5 both set, destination lane i takes its operands from the source field starting at bit i*D. This is the even source lane.
- R8: With ext bit 4 set and ext bit 5 clear, destination lane i takes its operands from the source field starting at bit i*D+S. This is the odd source lane. Any field starting at or beyond bit 64 reads as zero.
- R9: With ext bit 0 set, only destination lane 0 is computed, and every bit above it is copied from `old_dst`.
- R10: If the source size code exceeds the destination size code, `size_err` is high together with `done`, and `result` keeps its previous value. For a legal request, `size_err` is low with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src1 | input | 64 | First packed operand |
| src2 | input | 64 | Second packed operand |
| old_dst | input | 64 | Previous destination value, used for the lanes that are not written |
| src_size | input | 2 | Source lane size code |
| dst_size | input | 2 | Destination lane size code |
| ext | input | 6 | Option bits: 0 scalar, 1 signed, 2 round, 3 high half, 4 widen, 5 even lanes |
| done | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Registered packed result |
| size_err | output | 1 | Illegal size combination, pulses with done |

## Verification
The 16-bit lanes are first given all-ones operands. The unsigned low and high halves (0x0001 and 0xFFFE) differ there from anything a wrong half select would produce. Pairing 0xFFFF with 0x0002 separates signed from unsigned high halves (0xFFFF against 0x0001). The operands 0x4000 and 0x0003 produce a high half of 1 only if the rounding bias is applied. The 32-to-64-bit widening cases load different values into the two source halves, so the even and odd selections give different products. A swept set of random operands covers every legal size pair and all 64 option codes, and is compared against an independently coded 128-bit reference. Scalar mode and a rejected size pair are checked against the untouched upper lanes and the held result.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  localparam int unsigned WORD_W    = 64;
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned N_SIZES   = 4;
  localparam int unsigned EXT_W     = 6;

  // Option bits, packed so that bit 0 is the scalar flag.
  typedef struct packed {
    logic even_sel;   // bit 5
    logic widen;      // bit 4
    logic high;       // bit 3
    logic round;      // bit 2
    logic signed_op;  // bit 1
    logic scalar;     // bit 0
  } ext_t;

  // Width in bits of a lane for a size code.
  function automatic logic [6:0] code_to_bits(input logic [CODE_W-1:0] c);
    case (c)
      2'd0:    return 7'd8;
      2'd1:    return 7'd16;
      2'd2:    return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

  // Bit position where the operand field of a destination lane starts.
  function automatic int unsigned field_lo(input int unsigned lane,
                                           input int unsigned sbits,
                                           input int unsigned dbits,
                                           input logic widen,
                                           input logic even_sel);
    if (!widen)   return lane * sbits;
    if (even_sel) return lane * dbits;
    return lane * dbits + sbits;
  endfunction

  // Extract `width` bits of `w` starting at `lo`; beyond the word reads zero.
  function automatic logic [WORD_W-1:0] field_at(input logic [WORD_W-1:0] w,
                                                 input int unsigned lo,
                                                 input int unsigned width);
    logic [WORD_W-1:0] t;
    if (lo >= WORD_W) return '0;
    t = w >> lo;
    if (width < WORD_W) t = t & ((64'd1 << width) - 64'd1);
    return t;
  endfunction

endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a_fld,
  input  logic [DW-1:0] b_fld,
  input  logic [6:0]    sw,
  input  logic          signed_op,
  input  logic          round,
  input  logic          high,
  output logic [DW-1:0] lane_res
);

  localparam int unsigned PW = 2 * DW;
  localparam int unsigned IW = $clog2(DW);
  localparam logic [PW-1:0] ONES = '1;
  localparam logic [PW-1:0] RND  = {{(PW-1){1'b0}}, 1'b1} << (DW - 1);

  logic [IW-1:0] msb_idx;
  logic          a_neg, b_neg;
  logic [PW-1:0] a_x, b_x, prod, biased;

  assign msb_idx = IW'(sw - 7'd1);
  assign a_neg   = signed_op & a_fld[msb_idx];
  assign b_neg   = signed_op & b_fld[msb_idx];

  always_comb begin
    a_x = {{DW{1'b0}}, a_fld};
    b_x = {{DW{1'b0}}, b_fld};
    if (a_neg) a_x = a_x | (ONES << sw);
    if (b_neg) b_x = b_x | (ONES << sw);
    prod   = a_x * b_x;
    biased = round ? (prod + RND) : prod;
    lane_res = high ? biased[PW-1:DW] : biased[DW-1:0];
  end

endmodule

// File: rtl/pmul_group.sv
module pmul_group
  import pmul_pkg::*;
#(
  parameter int unsigned D_CODE = 1
) (
  input  logic [WORD_W-1:0] src1,
  input  logic [WORD_W-1:0] src2,
  input  logic [WORD_W-1:0] old_dst,
  input  logic [CODE_W-1:0] src_size,
  input  ext_t              ext_s,
  output logic [WORD_W-1:0] word
);

  localparam int unsigned DW    = 8 << D_CODE;
  localparam int unsigned LANES = WORD_W / DW;

  logic [CODE_W-1:0] s_eff;
  logic [6:0]        sbits;

  // Clamp so the lane never sees a source wider than itself.
  assign s_eff = (src_size > CODE_W'(D_CODE)) ? CODE_W'(D_CODE) : src_size;
  assign sbits = code_to_bits(s_eff);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DW-1:0] a_fld, b_fld, lane_res;
    logic          keep_old;
    int unsigned   lo;

    always_comb begin
      lo    = field_lo(i, int'(sbits), DW, ext_s.widen, ext_s.even_sel);
      a_fld = DW'(field_at(src1, lo, int'(sbits)));
      b_fld = DW'(field_at(src2, lo, int'(sbits)));
    end

    pmul_lane #(.DW(DW)) u_lane (
      .a_fld     (a_fld),
      .b_fld     (b_fld),
      .sw        (sbits),
      .signed_op (ext_s.signed_op),
      .round     (ext_s.round),
      .high      (ext_s.high),
      .lane_res  (lane_res)
    );

    assign keep_old = ext_s.scalar && (i != 0);
    assign word[i*DW +: DW] = keep_old ? old_dst[i*DW +: DW] : lane_res;
  end

endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] src1,
  input  logic [63:0] src2,
  input  logic [63:0] old_dst,
  input  logic [1:0]  src_size,
  input  logic [1:0]  dst_size,
  input  logic [5:0]  ext,
  output logic        done,
  output logic [63:0] result,
  output logic        size_err
);

  ext_t              ext_s;
  logic [WORD_W-1:0] words [N_SIZES];
  logic [WORD_W-1:0] next_result;
  logic [WORD_W-1:0] upper_keep_mask;
  logic              sizes_bad;

  assign ext_s = ext_t'(ext);

  for (genvar d = 0; d < N_SIZES; d++) begin : g_size
    pmul_group #(.D_CODE(d)) u_grp (
      .src1     (src1),
      .src2     (src2),
      .old_dst  (old_dst),
      .src_size (src_size),
      .ext_s    (ext_s),
      .word     (words[d])
    );
  end

  assign next_result = words[dst_size];
  assign sizes_bad   = src_size > dst_size;

  // Bits above destination lane 0; observed by the checker for scalar mode.
  always_comb begin
    case (dst_size)
      2'd0:    upper_keep_mask = 64'hFFFF_FFFF_FFFF_FF00;
      2'd1:    upper_keep_mask = 64'hFFFF_FFFF_FFFF_0000;
      2'd2:    upper_keep_mask = 64'hFFFF_FFFF_0000_0000;
      default: upper_keep_mask = 64'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      size_err <= 1'b0;
      result   <= '0;
    end else begin
      done     <= in_valid;
      size_err <= in_valid & sizes_bad;
      if (in_valid && !sizes_bad) result <= next_result;
    end
  end

endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] old_dst,
  input logic        scalar,
  input logic        sizes_bad,
  input logic [63:0] upper_keep_mask,
  input logic        done,
  input logic [63:0] result,
  input logic        size_err
);

  a_r2_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);

  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  a_r10_reject_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sizes_bad) |=> (size_err && $stable(result)));

  a_r10_legal_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sizes_bad) |=> !size_err);

  a_r10_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> done);

  a_r9_scalar_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sizes_bad && scalar) |=>
      ((result & $past(upper_keep_mask)) == ($past(old_dst) & $past(upper_keep_mask))));

endmodule

bind pmul_unit pmul_unit_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .old_dst         (old_dst),
  .scalar          (ext[0]),
  .sizes_bad       (sizes_bad),
  .upper_keep_mask (upper_keep_mask),
  .done            (done),
  .result          (result),
  .size_err        (size_err)
);

// File: tb/pmul_unit_test.sv
module pmul_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src1 = '0, src2 = '0, old_dst = '0;
  logic [1:0]  src_size = '0, dst_size = '0;
  logic [5:0]  ext = '0;
  logic        done, size_err;
  logic [63:0] result;

  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] last_good = '0;

  always #10 clk = ~clk;  // 50 MHz

  pmul_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src1(src1), .src2(src2), .old_dst(old_dst),
    .src_size(src_size), .dst_size(dst_size), .ext(ext),
    .done(done), .result(result), .size_err(size_err)
  );

  // Reference: 128-bit arithmetic, lane by lane, coded from the requirements.
  function automatic logic [63:0] model(input logic [63:0] a_w, input logic [63:0] b_w,
                                        input logic [63:0] old_w, input int sc, input int dc,
                                        input logic [5:0] x);
    int S = 8 << sc;
    int D = 8 << dc;
    int n = x[0] ? 1 : 64 / D;
    logic [63:0]  r = old_w;
    logic [127:0] m, a, b, p;
    m = (128'd1 << S) - 128'd1;
    for (int i = 0; i < n; i++) begin
      int lo = x[4] ? (x[5] ? i * D : i * D + S) : i * S;
      a = (lo >= 64) ? 128'd0 : (({64'd0, a_w} >> lo) & m);
      b = (lo >= 64) ? 128'd0 : (({64'd0, b_w} >> lo) & m);
      if (x[1] && a[S-1]) a = a | ~m;
      if (x[1] && b[S-1]) b = b | ~m;
      p = a * b;
      if (x[2]) p = p + (128'd1 << (D - 1));
      if (x[3]) p = p >> D;
      for (int j = 0; j < D; j++) r[i*D + j] = p[j];
    end
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // One strobe; outputs are sampled on the falling edge after the capturing edge.
  task automatic run_vec(input string req, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] o, input int sc, input int dc,
                         input logic [5:0] x, input logic [63:0] exp, input logic exp_err);
    @(negedge clk);
    src1 = a; src2 = b; old_dst = o;
    src_size = 2'(sc); dst_size = 2'(dc); ext = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {req, " done"}, {63'd0, done}, 64'd1);
    check(req, "size_err", {63'd0, size_err}, {63'd0, exp_err});
    check(req, "result", result, exp);
    if (!exp_err) last_good = exp;
  endtask

  task automatic t_reset;
    check("R1", "done after reset", {63'd0, done}, 64'd0);
    check("R1", "size_err after reset", {63'd0, size_err}, 64'd0);
    check("R1", "result after reset", result, 64'd0);
  endtask

  task automatic t_low16;  // R3
    run_vec("R3", {4{16'hFFFF}}, {4{16'hFFFF}}, '0, 1, 1, 6'h00, 64'h0001_0001_0001_0001, 1'b0);
    run_vec("R3", 64'h0003_0005_0007_0009, 64'h0002_0002_0002_0002, '0, 1, 1, 6'h00,
            64'h0006_000A_000E_0012, 1'b0);
  endtask

  task automatic t_high16;  // R4 R5
    run_vec("R5", {4{16'hFFFF}}, {4{16'hFFFF}}, '0, 1, 1, 6'h08, 64'hFFFE_FFFE_FFFE_FFFE, 1'b0);
    run_vec("R5", {4{16'hFFFF}}, {4{16'h0002}}, '0, 1, 1, 6'h08, 64'h0001_0001_0001_0001, 1'b0);
    run_vec("R4", {4{16'hFFFF}}, {4{16'h0002}}, '0, 1, 1, 6'h0A, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    run_vec("R4", {4{16'h8000}}, {4{16'h8000}}, '0, 1, 1, 6'h0A, 64'h4000_4000_4000_4000, 1'b0);
  endtask

  task automatic t_round;  // R6
    run_vec("R6", {4{16'h4000}}, {4{16'h0003}}, '0, 1, 1, 6'h08, 64'h0, 1'b0);
    run_vec("R6", {4{16'h4000}}, {4{16'h0003}}, '0, 1, 1, 6'h0C, 64'h0001_0001_0001_0001, 1'b0);
  endtask

  task automatic t_widen;  // R7 R8
    run_vec("R7", 64'h0000_0002_0000_0003, 64'h0000_0005_0000_0007, '0, 2, 3, 6'h30,
            64'd21, 1'b0);
    run_vec("R8", 64'h0000_0002_0000_0003, 64'h0000_0005_0000_0007, '0, 2, 3, 6'h10,
            64'd10, 1'b0);
    run_vec("R8", 64'h0000_0002_FFFF_FFFF, 64'h0000_0003_FFFF_FFFF, '0, 2, 3, 6'h12,
            64'd6, 1'b0);
    // Equal sizes, odd selection: the last lane reads past bit 63 and yields 0.
    run_vec("R8", {4{16'h0003}}, {4{16'h0004}}, '0, 1, 1, 6'h10, 64'h0000_000C_000C_000C, 1'b0);
  endtask

  task automatic t_scalar;  // R9
    run_vec("R9", {4{16'h0003}}, {4{16'h0004}}, 64'hAAAA_BBBB_CCCC_DDDD, 1, 1, 6'h01,
            64'hAAAA_BBBB_CCCC_000C, 1'b0);
    run_vec("R9", {8{8'h10}}, {8{8'h10}}, 64'h1122_3344_5566_7788, 0, 0, 6'h09,
            64'h1122_3344_5566_7701, 1'b0);
  endtask

  task automatic t_reject;  // R10
    logic [63:0] held = last_good;
    run_vec("R10", 64'h1234, 64'h5678, '0, 2, 1, 6'h00, held, 1'b1);
    run_vec("R10", 64'h1234, 64'h5678, '0, 3, 0, 6'h08, held, 1'b1);
  endtask

  task automatic t_idle;  // R2
    logic [63:0] held = last_good;
    repeat (3) @(negedge clk);
    check("R2", "done while idle", {63'd0, done}, 64'd0);
    check("R2", "result held while idle", result, held);
  endtask

  task automatic t_sweep;
    for (int sc = 0; sc < 4; sc++) begin
      for (int dc = sc; dc < 4; dc++) begin
        for (int x = 0; x < 64; x++) begin
          logic [63:0] a = {$urandom, $urandom};
          logic [63:0] b = {$urandom, $urandom};
          logic [63:0] o = {$urandom, $urandom};
          logic [5:0]  xe = 6'(x);
          string tag;
          if (xe[4])      tag = xe[5] ? "R7" : "R8";
          else if (xe[0]) tag = "R9";
          else if (xe[2]) tag = "R6";
          else if (xe[3]) tag = "R5";
          else if (xe[1]) tag = "R4";
          else            tag = "R3";
          run_vec(tag, a, b, o, sc, dc, xe, model(a, b, o, sc, dc, xe), 1'b0);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_low16;
    t_high16;
    t_round;
    t_widen;
    t_scalar;
    t_reject;
    t_idle;
    t_sweep;
    t_idle;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: got no completion, expected end of run");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule